// File: doc/BRIEF.md
# Vertical Trace Source Sequencer

This block is the digital control for the vertical signal path of a multi-trace oscilloscope. From five mode selections (channel 1, channel 2, trigger view, sum, X-Y) it decides which analog signal gate drives the vertical amplifier at any moment. It provides one enable for each of the three signal gates and a separate enable for the extra bias current that the sum display needs. When more than one source is selected, it steps through the selected sources. The step rate is either a fast chop tick divided down inside the block from the system clock, or one step per end-of-sweep strobe (alternate display).

X-Y operation takes priority over every other selection. It routes channel 2 alone as the vertical signal and stops all stepping. A single selected source freezes the sequence. The sum step turns on both channel gates together with the sum enable, whether or not either channel is selected by itself. All control is synchronous to one clock. A change of any source or X-Y selection restarts the sequence at the first selected source.

Top module: `vtrace_sequencer`

## Requirements
- R1: While the synchronous reset `rst` is high and for the first cycle after it, the outputs show the first selected source. Sources are ranked CH1, CH2, trigger view, sum.
- R2: While `xy_mode` is 1, only `gate_ch2` is on, whatever the other source selections are, and no stepping takes place.
- R3: When no more than one source is selected (or X-Y is on), the outputs stay fixed, regardless of elapsed time, chop ticks or `sweep_end` pulses.
- R4: The output vector {gate_ch1, gate_ch2, gate_tview, add_on} is 1000 for CH1 alone, 0100 for CH2 alone and 0010 for trigger view alone.
- R5: In the sum step, `gate_ch1`, `gate_ch2` and `add_on` are all 1 and `gate_tview` is 0. Selecting sum alone gives this step.
- R6: With several sources selected, the sequence visits only the selected ones in the order CH1, CH2, trigger view, sum, then wraps to the first.
- R7: With `chop_en` = 1, the sequence advances once every CLK_HZ/CHOP_HZ clocks, counted from the cycle after a mode change, and `sweep_end` has no effect.
- R8: With `chop_en` = 0, the sequence advances one step on the clock edge at which `sweep_end` is 1, and never without it.
- R9: Any change of `sel_ch1`, `sel_ch2`, `sel_tview`, `sel_add` or `xy_mode` makes the outputs show the first selected source of the new set, starting in the same cycle.
- R10: With no source selected and `xy_mode` = 0, all four outputs are 0.
- R11: `gate_tview` is never 1 while either channel gate is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_ch1 | input | 1 | Channel 1 selected |
| sel_ch2 | input | 1 | Channel 2 selected |
| sel_tview | input | 1 | Trigger view selected |
| sel_add | input | 1 | Sum display selected |
| xy_mode | input | 1 | X-Y override |
| chop_en | input | 1 | 1 = chop stepping, 0 = alternate stepping |
| sweep_end | input | 1 | End-of-sweep strobe, one clock per sweep |
| gate_ch1 | output | 1 | Channel 1 signal gate enable |
| gate_ch2 | output | 1 | Channel 2 signal gate enable |
| gate_tview | output | 1 | Trigger view signal gate enable |
| add_on | output | 1 | Sum bias current enable |

## Verification
A vector table walks every single selection, the empty set, several X-Y combinations with other bits set, and a few multi-source sets. This separates the priority decode from the stepping logic, because the first source shown must follow the fixed ranking. Single and X-Y patterns are then held while chop ticks and sweep strobes arrive, which shows that stepping is really frozen. A full four-source set and a sparse set (CH1 plus sum) are stepped in chop mode, sampled at exact multiples of the divider. These runs catch errors in skip order, in wrap-around and in tick timing, and also show that a stray strobe during chop does nothing. Alternate runs with a mode change part-way through tell strobe-driven stepping apart from restart-on-change.

// File: rtl/vts_pkg.sv
package vts_pkg;

   localparam int NSRC = 4;

   typedef enum logic [1:0] {
      STP_CH1 = 2'd0,
      STP_CH2 = 2'd1,
      STP_TV  = 2'd2,
      STP_ADD = 2'd3
   } step_t;

   // lowest ranked selected source; CH1 when the set is empty
   function automatic step_t first_set(input logic [NSRC-1:0] mask);
      step_t r;
      logic  found;
      r     = STP_CH1;
      found = 1'b0;
      for (int i = 0; i < NSRC; i++) begin
         if (!found && mask[i]) begin
            r     = step_t'(i[1:0]);
            found = 1'b1;
         end
      end
      return r;
   endfunction

   // next selected source after cur, wrapping; cur itself if alone
   function automatic step_t next_set(input logic [NSRC-1:0] mask, input step_t cur);
      step_t      r;
      logic       found;
      logic [1:0] idx;
      r     = cur;
      found = 1'b0;
      for (int k = 1; k <= NSRC; k++) begin
         idx = 2'(cur) + 2'(k);
         if (!found && mask[idx]) begin
            r     = step_t'(idx);
            found = 1'b1;
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/vts_mode_decode.sv
module vts_mode_decode
   import vts_pkg::*;
(
   input  logic            sel_ch1,
   input  logic            sel_ch2,
   input  logic            sel_tview,
   input  logic            sel_add,
   input  logic            xy_mode,
   output logic [NSRC-1:0] mask,
   output logic            multi
);

   logic [NSRC-1:0] raw;

   always_comb begin
      raw = {sel_add, sel_tview, sel_ch2, sel_ch1};
      // X-Y forces the channel 2 path and masks every other request
      if (xy_mode)
         mask = NSRC'(1) << STP_CH2;
      else
         mask = raw;
      multi = ($countones(mask) > 1);
   end

endmodule

// File: rtl/vts_chop_div.sv
module vts_chop_div #(
   parameter int DIV = 100
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic clr,
   output logic tick
);

   generate
      if (DIV < 1) begin : g_bad
         $error("vts_chop_div: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_every
         logic unused_ok;
         assign unused_ok = clk ^ rst;
         assign tick = en & ~clr;
      end else begin : g_count
         localparam int CNT_W = $clog2(DIV);
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk) begin
            if (rst || clr || !en)
               cnt <= '0;
            else if (cnt == CNT_W'(DIV - 1))
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end

         assign tick = en & ~clr & (cnt == CNT_W'(DIV - 1));
      end
   endgenerate

endmodule

// File: rtl/vts_step_ctrl.sv
module vts_step_ctrl
   import vts_pkg::*;
(
   input  logic            clk,
   input  logic            rst,
   input  logic [NSRC-1:0] mask,
   input  logic            restart,
   input  logic            adv,
   output step_t           eff
);

   step_t cur;
   step_t head;

   assign head = first_set(mask);

   always_ff @(posedge clk) begin
      if (rst || restart)
         cur <= head;
      else if (adv)
         cur <= next_set(mask, cur);
   end

   // a restart shows the new head in the same cycle
   assign eff = (rst || restart) ? head : cur;

endmodule

// File: rtl/vtrace_sequencer.sv
module vtrace_sequencer
   import vts_pkg::*;
#(
   parameter int CLK_HZ  = 100_000_000,
   parameter int CHOP_HZ = 1_000_000
) (
   input  logic clk,
   input  logic rst,
   input  logic sel_ch1,
   input  logic sel_ch2,
   input  logic sel_tview,
   input  logic sel_add,
   input  logic xy_mode,
   input  logic chop_en,
   input  logic sweep_end,
   output logic gate_ch1,
   output logic gate_ch2,
   output logic gate_tview,
   output logic add_on
);

   localparam int DIV    = (CHOP_HZ > 0) ? CLK_HZ / CHOP_HZ : 1;
   localparam int MODE_W = 5;

   generate
      if (CHOP_HZ <= 0 || CLK_HZ < CHOP_HZ) begin : g_chk_rate
         $error("vtrace_sequencer: CHOP_HZ must be positive and not above CLK_HZ");
      end
   endgenerate

   logic [NSRC-1:0]   mask;
   logic              multi;
   logic [MODE_W-1:0] mode_now;
   logic [MODE_W-1:0] mode_q;
   logic              mode_chg;
   logic              chop_tick;
   logic              adv;
   step_t             eff;
   logic              live;

   vts_mode_decode u_dec (
      .sel_ch1   (sel_ch1),
      .sel_ch2   (sel_ch2),
      .sel_tview (sel_tview),
      .sel_add   (sel_add),
      .xy_mode   (xy_mode),
      .mask      (mask),
      .multi     (multi)
   );

   assign mode_now = {xy_mode, sel_add, sel_tview, sel_ch2, sel_ch1};

   always_ff @(posedge clk) begin
      mode_q <= mode_now;
   end

   assign mode_chg = (mode_now != mode_q);

   vts_chop_div #(.DIV(DIV)) u_div (
      .clk  (clk),
      .rst  (rst),
      .en   (multi & chop_en),
      .clr  (mode_chg),
      .tick (chop_tick)
   );

   always_comb begin
      if (!multi || mode_chg)
         adv = 1'b0;
      else if (chop_en)
         adv = chop_tick;
      else
         adv = sweep_end;
   end

   vts_step_ctrl u_step (
      .clk     (clk),
      .rst     (rst),
      .mask    (mask),
      .restart (mode_chg),
      .adv     (adv),
      .eff     (eff)
   );

   assign live = |(mask & (NSRC'(1) << eff));

   always_comb begin
      gate_ch1   = live & ((eff == STP_CH1) | (eff == STP_ADD));
      gate_ch2   = live & ((eff == STP_CH2) | (eff == STP_ADD));
      gate_tview = live & (eff == STP_TV);
      add_on     = live & (eff == STP_ADD);
   end

endmodule

// File: rtl/vtrace_sequencer_chk.sv
module vtrace_sequencer_chk (
   input logic clk,
   input logic rst,
   input logic sel_ch1,
   input logic sel_ch2,
   input logic sel_tview,
   input logic sel_add,
   input logic xy_mode,
   input logic chop_en,
   input logic sweep_end,
   input logic gate_ch1,
   input logic gate_ch2,
   input logic gate_tview,
   input logic add_on
);

   logic [4:0] mode;
   logic [3:0] gates;
   logic       one_src;

   assign mode    = {xy_mode, sel_add, sel_tview, sel_ch2, sel_ch1};
   assign gates   = {gate_ch1, gate_ch2, gate_tview, add_on};
   assign one_src = xy_mode || ($countones({sel_add, sel_tview, sel_ch2, sel_ch1}) <= 1);

   AST_XY_CH2_ONLY: assert property (@(posedge clk) disable iff (rst)
      xy_mode |-> (gates == 4'b0100)); // R2

   AST_NONE_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
      (mode == 5'b00000) |-> (gates == 4'b0000)); // R10

   AST_ADD_BOTH_CH: assert property (@(posedge clk) disable iff (rst)
      add_on |-> (gate_ch1 && gate_ch2 && !gate_tview)); // R5

   AST_TV_EXCL: assert property (@(posedge clk) disable iff (rst)
      gate_tview |-> !(gate_ch1 || gate_ch2)); // R11

   AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (one_src && $stable(mode)) |-> $stable(gates)); // R3

   AST_ALT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
      (!$past(chop_en) && !$past(sweep_end) && $stable(mode)) |-> $stable(gates)); // R8

endmodule

bind vtrace_sequencer vtrace_sequencer_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .sel_ch1    (sel_ch1),
   .sel_ch2    (sel_ch2),
   .sel_tview  (sel_tview),
   .sel_add    (sel_add),
   .xy_mode    (xy_mode),
   .chop_en    (chop_en),
   .sweep_end  (sweep_end),
   .gate_ch1   (gate_ch1),
   .gate_ch2   (gate_ch2),
   .gate_tview (gate_tview),
   .add_on     (add_on)
);

// File: tb/vtrace_sequencer_test.sv
module vtrace_sequencer_test;

   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 8;
   localparam int NVEC       = 11;

   // {xy, add, tview, ch2, ch1} , expected {g1, g2, gtv, add}
   localparam logic [8:0] VEC [NVEC] = '{
      {5'b00000, 4'b0000},
      {5'b00001, 4'b1000},
      {5'b00010, 4'b0100},
      {5'b00100, 4'b0010},
      {5'b01000, 4'b1101},
      {5'b10000, 4'b0100},
      {5'b11111, 4'b0100},
      {5'b10101, 4'b0100},
      {5'b00110, 4'b0100},
      {5'b01100, 4'b0010},
      {5'b01111, 4'b1000}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sel_ch1 = 0, sel_ch2 = 0, sel_tview = 0, sel_add = 0, xy_mode = 0;
   logic chop_en = 1'b1;
   logic sweep_end = 1'b0;
   logic gate_ch1, gate_ch2, gate_tview, add_on;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vtrace_sequencer #(.CLK_HZ(DIV), .CHOP_HZ(1)) uut (
      .clk(clk), .rst(rst),
      .sel_ch1(sel_ch1), .sel_ch2(sel_ch2), .sel_tview(sel_tview),
      .sel_add(sel_add), .xy_mode(xy_mode),
      .chop_en(chop_en), .sweep_end(sweep_end),
      .gate_ch1(gate_ch1), .gate_ch2(gate_ch2),
      .gate_tview(gate_tview), .add_on(add_on)
   );

   function automatic logic [3:0] outs();
      return {gate_ch1, gate_ch2, gate_tview, add_on};
   endfunction

   task automatic chk(input string req, input logic [3:0] exp);
      total++;
      if (outs() !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b", req, outs(), exp);
      end
   endtask

   task automatic set_mode(input logic [4:0] m);
      {xy_mode, sel_add, sel_tview, sel_ch2, sel_ch1} = m;
   endtask

   // advance n rising edges, return at the following falling edge
   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic strobe();
      sweep_end = 1'b1;
      step(1);
      sweep_end = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: reset with full set selected
      set_mode(5'b01111);
      step(3);
      chk("R1 during reset", 4'b1000);
      rst = 1'b0;
      step(1);
      chk("R1 after reset", 4'b1000);

      // table walk: first shown source and frozen single cases
      for (int i = 0; i < NVEC; i++) begin
         logic [4:0] m;
         logic [3:0] e;
         logic       many;
         m = VEC[i][8:4];
         e = VEC[i][3:0];
         many = !m[4] && ($countones(m[3:0]) > 1);
         chop_en = 1'b1;
         set_mode(m);
         step(1);
         if (m == 5'b00000)      chk("R10 none selected", e);
         else if (m[4])          chk("R2 xy override", e);
         else if (m == 5'b01000) chk("R5 add alone", e);
         else if (many)          chk("R9 first of set", e);
         else                    chk("R4 single source", e);
         if (!many) begin
            step(3 * DIV);
            strobe();
            chop_en = 1'b0;
            strobe();
            step(5);
            chk(m[4] ? "R2 xy frozen" : "R3 single held", e);
            chop_en = 1'b1;
         end
      end

      // R6 R7: chop through all four, stray strobe ignored
      set_mode(5'b00000);
      step(1);
      chop_en = 1'b1;
      set_mode(5'b01111);
      step(1);
      chk("R6 chop step0", 4'b1000);
      strobe();
      step(6);
      chk("R7 strobe ignored in chop", 4'b1000);
      step(1);
      chk("R7 chop step1", 4'b0100);
      step(DIV);
      chk("R6 chop step2", 4'b0010);
      step(DIV);
      chk("R5 chop add step", 4'b1101);
      step(DIV);
      chk("R6 chop wrap", 4'b1000);

      // R11: exclusivity over a full chop cycle
      begin
         int viol = 0;
         for (int c = 0; c < 4 * DIV; c++) begin
            if (gate_tview && (gate_ch1 || gate_ch2)) viol++;
            step(1);
         end
         total++;
         if (viol != 0) begin
            bad++;
            $display("FAIL R11 exclusivity: got %0d violations expected 0", viol);
         end
      end

      // R6: sparse set skips CH2 and trigger view
      set_mode(5'b01001);
      step(1);
      chk("R6 sparse first", 4'b1000);
      step(DIV);
      chk("R6 sparse skip to add", 4'b1101);
      step(DIV);
      chk("R6 sparse wrap", 4'b1000);

      // R8: alternate stepping
      chop_en = 1'b0;
      set_mode(5'b00111);
      step(1);
      chk("R8 alt start", 4'b1000);
      step(3 * DIV);
      chk("R8 no strobe no step", 4'b1000);
      strobe();
      chk("R8 alt step1", 4'b0100);
      strobe();
      chk("R8 alt step2", 4'b0010);

      // R9: change mid-sequence restarts
      set_mode(5'b00110);
      step(1);
      chk("R9 restart on change", 4'b0100);
      strobe();
      chk("R8 alt two-source", 4'b0010);
      set_mode(5'b00111);
      step(1);
      chk("R9 restart back", 4'b1000);
      strobe();
      strobe();
      strobe();
      chk("R8 alt wrap", 4'b1000);

      // R2: xy set mid-run in chop mode
      chop_en = 1'b1;
      set_mode(5'b11111);
      step(1);
      chk("R2 xy immediate", 4'b0100);
      step(4 * DIV);
      chk("R2 xy no chop", 4'b0100);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule